// File: doc/BRIEF.md
# Fuse-Programmed Sum-of-Products Array

This block is the programmable AND-OR core of a ten-output registered logic device. It is configured from a linear fuse image of 5828 bits. Twenty-two input and feedback signals fan out into 44 array columns, one true and one complement per signal. Each of the 132 product-term rows takes the AND of whichever columns its 44 fuses connect. Groups of rows are then ORed into ten sums. Each output also gets its own output-enable term. One reset term and one preset term are shared by all outputs, and each output has a two-bit mode field that the macrocell logic downstream decodes.

The fuse image is written serially, one bit per clock, at an address that counts up from zero. A restart pulse rewinds the address. When the last fuse has been written, a done flag rises, and only then are the array outputs driven. The outputs are registered, so they reflect the inputs sampled at the previous clock edge.

Top module: `sop_fuse_array`

## Requirements
- R1: After reset, `load_done` is 0 and every output of the array (`sum_out`, `oe_out`, `rst_term`, `pre_term`, `mode_out`) is 0.
- R2: `load_start` rewinds the write address to 0 and clears `load_done`. It takes priority over a write in the same cycle. Each cycle with `load_valid` high, and no restart, stores `load_bit` at the current address, and the address then increments by one.
- R3: `load_done` rises in the cycle after the write to address 5827, which is the 5828th fuse. Once it is set, further writes are ignored and the stored image is left untouched until the next `load_start`.
- R4: While `load_done` is 0, all array outputs are 0 from the next clock edge on.
- R5: Column 2k carries `in_vec[k]` and column 2k+1 carries its complement. The fuse of row r, column c sits at address r*44+c. A fuse value of 0 connects that column into the row's AND. A row whose fuses are all 1 evaluates to 1.
- R6: A row that connects both the true and the complement column of the same input evaluates to 0. An all-zero image therefore drives every term and sum to 0.
- R7: Row 0 (addresses 0 to 43) drives `rst_term`. Row 131 (starting at address 5764) drives `pre_term`. Between them, output groups 0 to 9 follow in address order. Each group is one output-enable row followed by 8, 10, 12, 14, 16, 16, 14, 12, 10 and 8 logic rows respectively. Group 0 therefore spans addresses 44 to 439.
- R8: `sum_out[g]` is the OR of group g's logic rows only. The group's output-enable row drives `oe_out[g]` and does not enter the sum.
- R9: `mode_out[2g]` is the fuse at address 5808+2g and `mode_out[2g+1]` is the fuse at address 5809+2g.
- R10: The array outputs are registered. A change on `in_vec` appears on the outputs after the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load_start | input | 1 | Rewind the fuse address and clear done |
| load_valid | input | 1 | Write `load_bit` at the current address |
| load_bit | input | 1 | Fuse value to write |
| load_done | output | 1 | Image complete, outputs valid |
| in_vec | input | 22 | Array input and feedback signals |
| sum_out | output | 10 | Per-output OR of logic terms |
| oe_out | output | 10 | Per-output enable term |
| rst_term | output | 1 | Shared reset term |
| pre_term | output | 1 | Shared preset term |
| mode_out | output | 20 | Two mode bits per output |

## Verification
The assertions assume that `load_valid` and `load_start` are never X after reset. They also assume that a load is never abandoned between a restart and the done flag, except through another restart. The stimulus meets this by driving every control input at the falling edge from a single sequencing process. Every interrupted load is followed at once by a new `load_start`. Extra writes are issued only after done, where they must have no effect.

// File: rtl/sop_pkg.sv
package sop_pkg;
    parameter int NUM_IN    = 22;
    parameter int NUM_OUT   = 10;
    parameter int MIN_TERMS = 8;
    parameter int TERM_STEP = 2;

    localparam int COLS = 2 * NUM_IN;

    // logic rows for group g: grows toward the middle outputs
    function automatic int grp_terms(input int g);
        int d;
        d = (g < NUM_OUT - 1 - g) ? g : NUM_OUT - 1 - g;
        return MIN_TERMS + TERM_STEP * d;
    endfunction

    // row index of the enable row of group g (row 0 is the reset term)
    function automatic int grp_oe_row(input int g);
        int r;
        r = 1;
        for (int h = 0; h < g; h++) r = r + grp_terms(h) + 1;
        return r;
    endfunction

    localparam int ROWS       = grp_oe_row(NUM_OUT) + 1;
    localparam int ARRAY_BITS = ROWS * COLS;
    localparam int MODE_BITS  = 2 * NUM_OUT;
    localparam int FUSES      = ARRAY_BITS + MODE_BITS;
    localparam int ADDR_W     = $clog2(FUSES);

    typedef struct packed {
        logic [MODE_BITS-1:0] mode;
        logic                 pre;
        logic                 rst;
        logic [NUM_OUT-1:0]   oe;
        logic [NUM_OUT-1:0]   sum;
    } plane_out_t;
endpackage

// File: rtl/sop_fuse_loader.sv
module sop_fuse_loader
    import sop_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_start,
    input  logic             load_valid,
    input  logic             load_bit,
    output logic             load_done,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [FUSES-1:0] fuses
);
    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(FUSES - 1);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              done;
        logic [FUSES-1:0]  fuses;
    } ld_state_t;

    ld_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_start) begin
            st_d.addr = '0;
            st_d.done = 1'b0;
        end else if (load_valid && !st_q.done) begin
            st_d.fuses[st_q.addr] = load_bit;
            if (st_q.addr == LAST_ADDR) st_d.done = 1'b1;
            else                        st_d.addr = st_q.addr + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.addr  <= '0;
            st_q.done  <= 1'b0;
            st_q.fuses <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign load_done = st_q.done;
    assign wr_addr   = st_q.addr;
    assign fuses     = st_q.fuses;
endmodule

// File: rtl/sop_and_plane.sv
module sop_and_plane
    import sop_pkg::*;
(
    input  logic [NUM_IN-1:0]     in_vec,
    input  logic [ARRAY_BITS-1:0] array_fuses,
    output logic [ROWS-1:0]       row_val
);
    logic [COLS-1:0] col_vec;

    for (genvar k = 0; k < NUM_IN; k++) begin : g_col
        assign col_vec[2*k]   = in_vec[k];
        assign col_vec[2*k+1] = ~in_vec[k];
    end

    // a fuse at 0 makes its column mandatory; a 1 masks the column out
    for (genvar r = 0; r < ROWS; r++) begin : g_row
        assign row_val[r] = &(col_vec | array_fuses[r*COLS +: COLS]);
    end
endmodule

// File: rtl/sop_or_plane.sv
module sop_or_plane
    import sop_pkg::*;
(
    input  logic [ROWS-1:0]    row_val,
    output logic [NUM_OUT-1:0] sum,
    output logic [NUM_OUT-1:0] oe,
    output logic               rst,
    output logic               pre
);
    assign rst = row_val[0];
    assign pre = row_val[ROWS-1];

    for (genvar g = 0; g < NUM_OUT; g++) begin : g_grp
        localparam int FIRST = grp_oe_row(g);
        localparam int NT    = grp_terms(g);
        assign oe[g]  = row_val[FIRST];
        assign sum[g] = |row_val[FIRST+1 +: NT];
    end
endmodule

// File: rtl/sop_fuse_array.sv
module sop_fuse_array
    import sop_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load_start,
    input  logic                 load_valid,
    input  logic                 load_bit,
    output logic                 load_done,
    input  logic [NUM_IN-1:0]    in_vec,
    output logic [NUM_OUT-1:0]   sum_out,
    output logic [NUM_OUT-1:0]   oe_out,
    output logic                 rst_term,
    output logic                 pre_term,
    output logic [MODE_BITS-1:0] mode_out
);
    logic [ADDR_W-1:0]  wr_addr;
    logic [FUSES-1:0]   fuses;
    logic [ROWS-1:0]    row_val;
    logic [NUM_OUT-1:0] sum_c, oe_c;
    logic               rst_c, pre_c;

    sop_fuse_loader u_loader (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_start (load_start),
        .load_valid (load_valid),
        .load_bit   (load_bit),
        .load_done  (load_done),
        .wr_addr    (wr_addr),
        .fuses      (fuses)
    );

    sop_and_plane u_and (
        .in_vec      (in_vec),
        .array_fuses (fuses[ARRAY_BITS-1:0]),
        .row_val     (row_val)
    );

    sop_or_plane u_or (
        .row_val (row_val),
        .sum     (sum_c),
        .oe      (oe_c),
        .rst     (rst_c),
        .pre     (pre_c)
    );

    plane_out_t out_d, out_q;

    always_comb begin
        out_d = '0;
        if (load_done) begin
            out_d.sum  = sum_c;
            out_d.oe   = oe_c;
            out_d.rst  = rst_c;
            out_d.pre  = pre_c;
            out_d.mode = fuses[ARRAY_BITS +: MODE_BITS];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign sum_out  = out_q.sum;
    assign oe_out   = out_q.oe;
    assign rst_term = out_q.rst;
    assign pre_term = out_q.pre;
    assign mode_out = out_q.mode;
endmodule

// File: rtl/sop_fuse_array_chk.sv
module sop_fuse_array_chk
    import sop_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 load_start,
    input logic                 load_valid,
    input logic                 load_done,
    input logic [ADDR_W-1:0]    wr_addr,
    input logic [NUM_OUT-1:0]   sum_out,
    input logic [NUM_OUT-1:0]   oe_out,
    input logic                 rst_term,
    input logic                 pre_term,
    input logic [MODE_BITS-1:0] mode_out
);
    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(FUSES - 1);

    assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !load_done |=> (sum_out == '0 && oe_out == '0 && !rst_term && !pre_term && mode_out == '0));

    assert_start_rewinds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load_start |=> (!load_done && wr_addr == '0));

    assert_addr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (load_valid && !load_start && !load_done && wr_addr != LAST_ADDR)
        |=> wr_addr == $past(wr_addr) + 1'b1);

    assert_done_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (load_done && !load_start) |=> load_done);

    assert_done_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(load_done) |-> ($past(load_valid) && $past(wr_addr) == LAST_ADDR));
endmodule

bind sop_fuse_array sop_fuse_array_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_start (load_start),
    .load_valid (load_valid),
    .load_done  (load_done),
    .wr_addr    (wr_addr),
    .sum_out    (sum_out),
    .oe_out     (oe_out),
    .rst_term   (rst_term),
    .pre_term   (pre_term),
    .mode_out   (mode_out)
);

// File: tb/sop_fuse_array_tb_top.sv
`timescale 1ns/1ps
module sop_fuse_array_tb_top;
    localparam int NF   = 5828;
    localparam int NC   = 44;
    localparam int NROW = 132;
    localparam int OW   = 42;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_start = 1'b0, load_valid = 1'b0, load_bit = 1'b0;
    logic        load_done;
    logic [21:0] in_vec = '0;
    logic [9:0]  sum_out, oe_out;
    logic        rst_term, pre_term;
    logic [19:0] mode_out;

    int total = 0, bad = 0, cyc = 0;
    bit finished = 0;

    int          due_q[$];
    logic [OW-1:0] exp_q[$];
    string       tag_q[$];

    logic [NF-1:0] img_a, img_b, img_c;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    sop_fuse_array dut_i (
        .clk(clk), .rst_n(rst_n), .load_start(load_start), .load_valid(load_valid),
        .load_bit(load_bit), .load_done(load_done), .in_vec(in_vec),
        .sum_out(sum_out), .oe_out(oe_out), .rst_term(rst_term),
        .pre_term(pre_term), .mode_out(mode_out)
    );

    function automatic logic [OW-1:0] observed();
        return {mode_out, pre_term, rst_term, oe_out, sum_out};
    endfunction

    function automatic int terms_of(int g);
        int t[10] = '{8, 10, 12, 14, 16, 16, 14, 12, 10, 8};
        return t[g];
    endfunction

    // row evaluation per R5/R6
    function automatic logic row_eval(logic [NF-1:0] f, int r, logic [21:0] x);
        logic v = 1'b1;
        for (int k = 0; k < 22; k++) begin
            if (!f[r*NC + 2*k]     && !x[k]) v = 1'b0;
            if (!f[r*NC + 2*k + 1] &&  x[k]) v = 1'b0;
        end
        return v;
    endfunction

    // expected outputs per R7/R8/R9
    function automatic logic [OW-1:0] model(logic [NF-1:0] f, logic [21:0] x);
        logic [9:0]  s = '0, e = '0;
        logic [19:0] m;
        int pos = 1;
        for (int g = 0; g < 10; g++) begin
            e[g] = row_eval(f, pos, x);
            for (int j = 0; j < terms_of(g); j++) s[g] = s[g] | row_eval(f, pos + 1 + j, x);
            pos = pos + 1 + terms_of(g);
        end
        for (int i = 0; i < 20; i++) m[i] = f[5808 + i];
        return {m, row_eval(f, NROW - 1, x), row_eval(f, 0, x), e, s};
    endfunction

    task automatic check(string tag, logic [OW-1:0] act, logic [OW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // driver: sets inputs and queues the registered result (R10: one edge later)
    task automatic drive(logic [21:0] x, logic [OW-1:0] exp, string tag);
        @(negedge clk);
        in_vec = x;
        due_q.push_back(cyc + 1);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
    endtask

    // monitor: scoreboard compare
    always @(negedge clk) begin
        while (due_q.size() > 0 && due_q[0] == cyc) begin
            check(tag_q[0], observed(), exp_q[0]);
            void'(due_q.pop_front());
            void'(exp_q.pop_front());
            void'(tag_q.pop_front());
        end
    end

    task automatic load_img(logic [NF-1:0] im, int count);
        @(negedge clk);
        load_start = 1'b1;
        load_valid = 1'b1;
        load_bit   = 1'b0;
        @(negedge clk);
        load_start = 1'b0;
        for (int i = 0; i < count; i++) begin
            load_valid = 1'b1;
            load_bit   = im[i];
            @(negedge clk);
        end
        load_valid = 1'b0;
    endtask

    task automatic run_patterns(logic [NF-1:0] im, string tag);
        logic [21:0] pats[4] = '{22'h000000, 22'h3FFFFF, 22'h155555, 22'h2AAAAA};
        foreach (pats[p]) drive(pats[p], model(im, pats[p]), tag);
        for (int k = 0; k < 22; k++) drive(22'(1) << k, model(im, 22'(1) << k), tag);
        repeat (3) @(negedge clk);
    endtask

    function automatic void row_reopen(inout logic [NF-1:0] f, input int r);
        f[r*NC] = 1'b1;
        f[r*NC + 1] = 1'b1;
    endfunction

    initial begin
        int pos;
        img_a = '1;
        for (int i = 0; i < 20; i++) img_a[5808 + i] = i[0] ^ i[2];
        img_b = '0;
        img_c = '1;
        for (int r = 0; r < NROW; r++) begin
            img_c[r*NC] = 1'b0;
            img_c[r*NC + 1] = 1'b0;
        end
        row_reopen(img_c, 0);       img_c[40] = 1'b0;            // rst = in[20]
        row_reopen(img_c, NROW-1);  img_c[(NROW-1)*NC + 43] = 1'b0; // pre = ~in[21]
        pos = 1;
        for (int g = 0; g < 10; g++) begin
            row_reopen(img_c, pos);
            if (g != 9) img_c[pos*NC + 2*(g+10) + 1] = 1'b0;    // oe = ~in[g+10]
            if (g != 9) begin
                int r;
                r = pos + 1 + ((g % 2 == 0) ? 0 : terms_of(g) - 1);
                row_reopen(img_c, r);
                img_c[r*NC + 2*g] = 1'b0;                        // sum = in[g]
            end
            pos = pos + 1 + terms_of(g);
        end
        for (int i = 0; i < 20; i++) img_c[5808 + i] = (i % 3 == 0);

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 reset outputs", observed(), '0);
        check("R1 reset done", {41'b0, load_done}, '0);

        // R4: partial load keeps outputs quiet
        load_img(img_c, 300);
        check("R2 partial no done", {41'b0, load_done}, '0);
        drive(22'h3FFFFF, '0, "R4 quiet before done");
        drive(22'h000000, '0, "R4 quiet before done");

        // R2/R3: restart and full load
        load_img(img_c, NF);
        check("R3 done after last fuse", {41'b0, load_done}, {41'b0, 1'b1});
        run_patterns(img_c, "R5 R7 R8 R10 image C");

        // R3: extra writes after done ignored
        for (int i = 0; i < 64; i++) begin
            load_valid = 1'b1;
            load_bit   = 1'b0;
            @(negedge clk);
        end
        load_valid = 1'b0;
        check("R3 done held", {41'b0, load_done}, {41'b0, 1'b1});
        run_patterns(img_c, "R3 writes ignored");

        // R5 all-open rows, R9 mode bits
        load_img(img_a, NF);
        run_patterns(img_a, "R5 R9 image A");

        // R6 all-connected rows
        load_img(img_b, NF);
        run_patterns(img_b, "R6 image B");

        repeat (4) @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule